// File: doc/BRIEF.md
# Program Status Doubleword Exchange Unit

This unit performs the status-word part of a context switch on a 64-bit program status doubleword. A start pulse supplies the following items:

- the current status word;
- a doubleword effective address in word units;
- two instruction modifier bits: a register-pointer load bit and an address-adjust bit;
- a 2-bit trap context;
- a 4-bit R field;
- a 4-bit trap condition code.

Over a single request/acknowledge memory port, the unit first writes the current status word to the effective address. It then reads the doubleword two words higher. Bit numbering in this project runs from 0 at the most significant (leftmost) bit to 63 at the least significant bit.

The fetched doubleword is not simply loaded into the status register. The unit builds the new word from several parts:

- some fields are replaced by the fetched word;
- the interrupt inhibits are OR-merged with their current values;
- the register pointer is loaded only on request;
- trap contexts can OR extra bits into the condition code and can raise the instruction address.

A one-cycle done pulse marks the cycle in which the new word appears on the status output.

Top module: `psx_exchange`

## Requirements
- R1: After an accepted start, the unit issues a write of the captured current word to address `ea`, then a read from address `ea + 2` (modulo 2^ADDR_W). Each access is a single request with `mem_we` high for the write and low for the read.
- R2: Bits 0–35, 60 and 61 of the new word equal the fetched word's bits, except where R5–R7 modify the condition code (bits 0–3) or the instruction address (bits 15–31).
- R3: Each of bits 37, 38 and 39 of the new word is the OR of the current bit and the fetched bit. A 1 sets the bit; a 0 leaves it unchanged.
- R4: With `lp_bit` = 1, bits 58–59 come from the fetched word. With `lp_bit` = 0, they keep the current value.
- R5: With `trap_ctx` = 2'b01 (call trap), `r_field` is ORed into bits 0–3, with `r_field[3]` going to bit 0. If `adj_bit` = 1, `r_field` is also added to bits 15–31.
- R6: With `trap_ctx` = 2'b10 (timer, parity or instruction-exception trap), `trap_cc` is ORed into bits 0–3 and, if `adj_bit` = 1, added to bits 15–31.
- R7: With `trap_ctx` = 2'b11 (nonallowed operation), bits 1 and 3 of the new word are set to 1. If `adj_bit` = 1, 5 is added to bits 15–31.
- R8: With `trap_ctx` = 2'b00, `adj_bit`, `r_field` and `trap_cc` have no effect. Whenever `adj_bit` = 0, bits 15–31 equal the fetched value.
- R9: Additions to bits 15–31 wrap modulo 2^17 and never alter bits 12–14 or bit 32.
- R10: Bits 36, 40–57, 62 and 63 keep their current values.
- R11: `done` is high for exactly one cycle, and in that cycle `psw_out` already holds the new word. A start while `busy` is high is ignored.
- R12: Once raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until the cycle in which `mem_ack` is high.
- R13: After reset, `psw_out` is 0 and `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exchange (accepted only when idle) |
| cur_psw | input | 64 | Current status word, bit 0 = MSB |
| ea | input | ADDR_W | Doubleword effective address (word units) |
| lp_bit | input | 1 | Register-pointer load modifier |
| adj_bit | input | 1 | Instruction-address adjust modifier |
| trap_ctx | input | 2 | 00 none, 01 call, 10 timer/parity/exception, 11 nonallowed op |
| r_field | input | 4 | R field of the trapping call |
| trap_cc | input | 4 | Trap condition code |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| psw_out | output | 64 | Status register |

## Verification
The merge is run under each of the four trap contexts, with the adjust bit both clear and set. This separates condition-code ORing from the address addition and shows that both are ignored outside a trap. The fetched and current words are chosen with opposite patterns in the inhibit, register-pointer and preserved bit ranges, so that a replace, an OR and a keep each give a different result. An instruction address of all ones, with zeros in bits 12–14, exposes any carry out of the 17-bit field. Varying the memory latency, together with a second start issued mid-exchange, checks the handshake order and that only one exchange runs at a time.

// File: rtl/psx_pkg.sv
package psx_pkg;
  typedef enum logic [1:0] {
    CTX_NONE = 2'b00,
    CTX_CALL = 2'b01,
    CTX_TCC  = 2'b10,
    CTX_NAO  = 2'b11
  } ctx_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_STORE = 2'b01,
    ST_FETCH = 2'b10
  } seq_e;

  localparam int IA_LO    = 15;
  localparam int IA_HI    = 31;
  localparam int IA_W     = IA_HI - IA_LO + 1;
  localparam logic [3:0] NAO_CC = 4'b0101;
  localparam int NAO_STEP = 5;
endpackage

// File: rtl/psx_merge.sv
module psx_merge
  import psx_pkg::*;
(
  input  logic [0:63] cur,
  input  logic [0:63] ed2,
  input  logic        lp,
  input  logic        adj,
  input  ctx_e        ctx,
  input  logic [3:0]  rf,
  input  logic [3:0]  tcc,
  output logic [0:63] nw
);
  logic [3:0]      cc_or;
  logic [IA_W-1:0] addend;

  always_comb begin
    case (ctx)
      CTX_CALL: begin cc_or = rf;     addend = IA_W'(rf);       end
      CTX_TCC:  begin cc_or = tcc;    addend = IA_W'(tcc);      end
      CTX_NAO:  begin cc_or = NAO_CC; addend = IA_W'(NAO_STEP); end
      default:  begin cc_or = 4'b0;   addend = '0;              end
    endcase
  end

  always_comb begin
    nw          = cur;
    nw[0:35]    = ed2[0:35];
    nw[37:39]   = cur[37:39] | ed2[37:39];
    nw[60:61]   = ed2[60:61];
    if (lp) nw[58:59] = ed2[58:59];
    nw[0:3]     = ed2[0:3] | cc_or;
    if (adj) nw[IA_LO:IA_HI] = ed2[IA_LO:IA_HI] + addend;
  end
endmodule

// File: rtl/psx_seq.sv
module psx_seq
  import psx_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] ea,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              accept,
  output logic              load_en,
  output logic              done
);
  seq_e              state;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  assign busy     = (state != ST_IDLE);
  assign accept   = start && !busy;
  assign load_en  = (state == ST_FETCH) && mem_ack;
  assign mem_req  = busy;
  assign mem_we   = (state == ST_STORE);
  assign mem_addr = addr_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= load_en;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_STORE;
          addr_q <= ea;
        end
        ST_STORE: if (mem_ack) begin
          state  <= ST_FETCH;
          addr_q <= addr_q + ADDR_W'(ADDR_STEP);
        end
        ST_FETCH: if (mem_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_order_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we);
endmodule

// File: rtl/psx_exchange.sv
module psx_exchange
  import psx_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [0:63]       cur_psw,
  input  logic [ADDR_W-1:0] ea,
  input  logic              lp_bit,
  input  logic              adj_bit,
  input  logic [1:0]        trap_ctx,
  input  logic [3:0]        r_field,
  input  logic [3:0]        trap_cc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [0:63]       mem_wdata,
  input  logic              mem_ack,
  input  logic [0:63]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [0:63]       psw_out
);
  logic        accept, load_en;
  logic [0:63] psw_q, merged;
  logic        lp_q, adj_q;
  ctx_e        ctx_q;
  logic [3:0]  rf_q, tcc_q;

  psx_seq #(.ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP)) u_seq (
    .clk(clk), .rst(rst), .start(start), .ea(ea), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .busy(busy), .accept(accept), .load_en(load_en), .done(done)
  );

  psx_merge u_merge (
    .cur(psw_q), .ed2(mem_rdata), .lp(lp_q), .adj(adj_q), .ctx(ctx_q),
    .rf(rf_q), .tcc(tcc_q), .nw(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q <= '0;
      lp_q  <= 1'b0;
      adj_q <= 1'b0;
      ctx_q <= CTX_NONE;
      rf_q  <= '0;
      tcc_q <= '0;
    end else if (accept) begin
      psw_q <= cur_psw;
      lp_q  <= lp_bit;
      adj_q <= adj_bit;
      ctx_q <= ctx_e'(trap_ctx);
      rf_q  <= r_field;
      tcc_q <= trap_cc;
    end else if (load_en) begin
      psw_q <= merged;
    end
  end

  assign psw_out   = psw_q;
  assign mem_wdata = psw_q;

  assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> psw_q[36] == $past(psw_q[36]) && psw_q[40:57] == $past(psw_q[40:57])
             && psw_q[62:63] == $past(psw_q[62:63]));
  assert_inhibit_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (($past(psw_q[37:39]) | $past(mem_rdata[37:39])) == psw_q[37:39]));
  assert_ia_plain_R8: assert property (@(posedge clk) disable iff (rst)
    done && (!adj_q || ctx_q == CTX_NONE) |-> psw_q[15:31] == $past(mem_rdata[15:31]));
  assert_wdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> $stable(mem_wdata));
endmodule

// File: tb/tb_psx_exchange.sv
module tb_psx_exchange;
  localparam int AW = 17;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [0:63] cur_psw = '0, mem_rdata = '0, mem_wdata, psw_out;
  logic [AW-1:0] ea = '0, mem_addr;
  logic lp_bit = 0, adj_bit = 0, mem_ack = 0, mem_req, mem_we, busy, done;
  logic [1:0] trap_ctx = 0;
  logic [3:0] r_field = 0, trap_cc = 0;

  int checks = 0, fails = 0, done_cnt = 0, lat = 0, wait_c = 0;
  bit finished = 0;
  logic [0:63] sb_q[$];
  logic [0:63] exp_cur, fetch_word;
  logic [AW-1:0] exp_ea;

  always #2 clk = ~clk;

  psx_exchange #(.ADDR_W(AW)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [0:63] model(input logic [0:63] c, input logic [0:63] e,
      input bit lp, input bit adj, input logic [1:0] ctx, input logic [3:0] r, input logic [3:0] t);
    logic [0:63] m;
    logic [3:0] orv, add;
    m = c;
    for (int i = 0; i < 64; i++) begin
      if (i <= 35 || i == 60 || i == 61) m[i] = e[i];
      else if (i >= 37 && i <= 39) m[i] = c[i] | e[i];
      else if ((i == 58 || i == 59) && lp) m[i] = e[i];
    end
    orv = (ctx == 2'b01) ? r : (ctx == 2'b10) ? t : (ctx == 2'b11) ? 4'b0101 : 4'b0000;
    add = (ctx == 2'b01) ? r : (ctx == 2'b10) ? t : (ctx == 2'b11) ? 4'd5 : 4'd0;
    m[0:3] = m[0:3] | orv;
    if (adj) m[15:31] = 17'(e[15:31] + 17'(add));
    return m;
  endfunction

  // memory model: checks the R1 access order and returns the fetch word
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_c >= lat) begin
        wait_c <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          chk(mem_addr == exp_ea, "R1 store addr", 64'(mem_addr), 64'(exp_ea));
          chk(mem_wdata == exp_cur, "R1 store data", mem_wdata, exp_cur);
        end else begin
          chk(mem_addr == AW'(exp_ea + 2), "R1 fetch addr", 64'(mem_addr), 64'(AW'(exp_ea + 2)));
          mem_rdata <= fetch_word;
        end
      end else wait_c <= wait_c + 1;
    end
  end

  // monitor: scoreboard compare on each done pulse (R11)
  always @(negedge clk) begin
    if (!rst && done) begin
      done_cnt++;
      if (sb_q.size() == 0) chk(0, "R11 unexpected done", psw_out, 64'h0);
      else begin
        logic [0:63] e;
        e = sb_q.pop_front();
        chk(psw_out == e, "R2-merge", psw_out, e);
      end
    end
  end

  task automatic run(input logic [0:63] c, input logic [AW-1:0] a, input bit lp, input bit adj,
      input logic [1:0] ctx, input logic [3:0] r, input logic [3:0] t, input logic [0:63] e,
      input int l, input bit poke);
    int n;
    n = done_cnt;
    @(negedge clk);
    exp_cur = c; exp_ea = a; fetch_word = e; lat = l;
    sb_q.push_back(model(c, e, lp, adj, ctx, r, t));
    cur_psw = c; ea = a; lp_bit = lp; adj_bit = adj; trap_ctx = ctx; r_field = r; trap_cc = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R11: start while busy must be ignored
      cur_psw = ~c; ea = a + 7; trap_ctx = 2'b11; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == n) @(negedge clk);
    @(negedge clk);
    chk(!done && !busy, "R11 single pulse", {62'b0, done, busy}, 64'h0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [0:63] c1, e1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(psw_out == 0 && !busy && !done && !mem_req, "R13 reset", psw_out, 64'h0);
    c1 = 64'hA5A5_0F0F_3C3C_F0F3;
    e1 = 64'h5A5A_F0F0_C3C3_0F0C;
    // R2 R3 R4 R10: plain merge, lp=1 and lp=0
    run(c1, 17'h00100, 1, 0, 2'b00, 4'h0, 4'h0, e1, 0, 0);
    run(c1, 17'h00200, 0, 0, 2'b00, 4'h0, 4'h0, e1, 2, 0);
    // R3: current inhibits set, fetched clear -> stay set
    run(64'h0000_0000_0700_0000, 17'h10, 0, 0, 2'b00, 4'h0, 4'h0, 64'hFFFF_FFFF_F0FF_FFFF, 1, 0);
    // R8: no trap context, adj set, fields ignored
    run(c1, 17'h300, 0, 1, 2'b00, 4'hF, 4'hF, e1, 0, 0);
    // R5: call trap, adj 0 then 1
    run(c1, 17'h400, 0, 0, 2'b01, 4'h5, 4'h0, e1, 1, 0);
    run(c1, 17'h402, 1, 1, 2'b01, 4'hA, 4'h3, e1, 3, 0);
    // R6: timer/parity/exception trap
    run(c1, 17'h500, 0, 1, 2'b10, 4'h1, 4'hC, e1, 0, 0);
    run(c1, 17'h502, 0, 0, 2'b10, 4'h1, 4'h9, e1, 2, 0);
    // R7: nonallowed operation
    run(c1, 17'h600, 0, 1, 2'b11, 4'h0, 4'h0, 64'h0, 1, 0);
    // R9: IA all ones with bits 12-14 zero, wrap without carry
    run(64'hFFFF_FFFF_FFFF_FFFF, 17'h1FFFF, 0, 1, 2'b11, 4'h0, 4'h0,
        64'h0001_FFFF_0000_0000, 0, 0);
    run(c1, 17'h1FFFE, 0, 1, 2'b01, 4'hF, 4'h0, 64'h0001_FFFE_0000_0000, 1, 0);
    // R11 R12: second start during busy, long latency
    run(c1, 17'h700, 1, 1, 2'b10, 4'h0, 4'h7, e1, 4, 1);
    chk(sb_q.size() == 0, "R11 queue drained", 64'(sb_q.size()), 64'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule